// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the serial slave side of a sampling data converter. A master drives a serial clock, an active-low chip select and a serial data line. The block answers on a serial data output that has an output enable, and it raises a busy flag. Internally the port moves through three phases. In the conversion phase a fixed-length cycle counter stands in for the modulator. In the sleep phase the finished result waits to be read. In the readout phase a 32-bit result word is shifted out while a 13-bit configuration word (speed code and channel) is shifted in.

The master can leave the readout phase early by raising chip select. Once enough bits have been exchanged, this starts the next conversion at once. A configuration word takes effect only when the frame ran long enough to deliver all of it. With chip select low and no clocks, the master sees a single status bit on the output, so it can poll whether a result is ready.

All serial pins are sampled by the block clock, which must run well above the serial clock. The configuration that governs the running conversion is brought out as two ports.

Top module: `cnv_serial_port`

## Requirements
- R1: After reset the block is converting (busy high), the data output enable is low while chip select is high, the speed code equals SPD_RST (default 1) and the channel equals CH_RST (default 0).
- R2: While chip select is high, sdo_oe is 0 (output in high impedance); while chip select is low, sdo_oe is 1.
- R3: With chip select low during a conversion, sdo reads 1 (result not ready) without any serial clock.
- R4: The readout word is 32 bits, MSB first. Bit 31 is 0 (result ready), bit 30 is 0, bit 29 is the result sign, bits 28..5 are the 24-bit result MSB first, and bits 4..0 are 0. Bit 31 is on sdo before the first falling serial clock edge, and each falling edge advances sdo by one bit.
- R5: sdi is sampled on the first 13 rising serial clock edges of a frame. The first 5 bits form the speed code, MSB first, and the next 8 form the channel, MSB first. They are committed to cfg_speed/cfg_chan when chip select rises after 14 or more falling edges, which includes a full 32-bit frame.
- R6: Raising chip select after 5 to 13 falling edges starts a new conversion at once (busy stays high, a poll reads 1) and leaves cfg_speed/cfg_chan unchanged.
- R7: Raising chip select after fewer than 5 falling edges returns the port to sleep (busy low) with the result and configuration kept. The next frame starts again from bit 31 with the same word.
- R8: busy is 1 during conversion and readout, and 0 during sleep.
- R9: A conversion lasts CONV_CYCLES block clock cycles from its start. The result and sign inputs are captured when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| csn | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial configuration data from the master |
| res_data | input | DATA_W | Conversion result magnitude |
| res_sign | input | 1 | Conversion result sign |
| sdo | output | 1 | Serial data / status output |
| sdo_oe | output | 1 | Output enable for sdo (0 means high impedance) |
| busy | output | 1 | High while converting or reading out |
| cfg_speed | output | SPD_W | Speed code in force |
| cfg_chan | output | CH_W | Channel in force |

## Verification
The assertions check on every cycle that the ready flag leads each readout word, that the configuration moves only on a commit, that a short abort goes back to sleep with the result intact, that the bit counter stays in range and that every start runs the conversion timer. Only the bench scenarios can show the full word layout for different results, the exact abort thresholds at 4/5 and 13/14 falling edges, the poll value during a conversion and the conversion length seen at the busy pin.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } cnv_state_e;
endpackage

// File: rtl/cnv_pin_sync.sv
module cnv_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csn,
  input  logic sdi,
  output logic csn_s,
  output logic sdi_s,
  output logic csn_rise,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic sclk_q, sclk_q2, csn_q, csn_q2, sdi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sclk_q2 <= 1'b0;
      csn_q   <= 1'b1;
      csn_q2  <= 1'b1;
      sdi_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      sclk_q2 <= sclk_q;
      csn_q   <= csn;
      csn_q2  <= csn_q;
      sdi_q   <= sdi;
    end
  end

  assign csn_s     = csn_q;
  assign sdi_s     = sdi_q;
  assign csn_rise  = csn_q & ~csn_q2;
  assign sclk_rise = sclk_q & ~sclk_q2;
  assign sclk_fall = ~sclk_q & sclk_q2;
endmodule

// File: rtl/cnv_conv_timer.sv
module cnv_conv_timer #(
  parameter int CONV_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign running = run_q;
  assign done    = run_q && (cnt_q == LAST) && !start;

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/cnv_frame_engine.sv
module cnv_frame_engine
  import cnv_pkg::*;
#(
  parameter int FRAME_W    = 32,
  parameter int DATA_W     = 24,
  parameter int SPD_W      = 5,
  parameter int CH_W       = 8,
  parameter int ABORT_MIN  = 5,
  parameter int COMMIT_MIN = 14,
  parameter logic [SPD_W-1:0] SPD_RST = 1,
  parameter logic [CH_W-1:0]  CH_RST  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              csn_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_sign,
  output logic              conv_start,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic [SPD_W-1:0]  cfg_speed,
  output logic [CH_W-1:0]   cfg_chan
);
  localparam int CFG_W = SPD_W + CH_W;
  localparam int PAD_W = FRAME_W - 3 - DATA_W;
  localparam int FCW   = $clog2(FRAME_W + 1);
  localparam int RCW   = $clog2(CFG_W + 1);
  localparam logic [FCW-1:0] FALL_MAX = FCW'(FRAME_W);
  localparam logic [FCW-1:0] ABORT_L  = FCW'(ABORT_MIN);
  localparam logic [FCW-1:0] COMMIT_L = FCW'(COMMIT_MIN);
  localparam logic [RCW-1:0] RISE_MAX = RCW'(CFG_W);

  cnv_state_e         state_q, state_d;
  logic [FCW-1:0]     fall_q, fall_d;
  logic [RCW-1:0]     rise_q, rise_d;
  logic [FRAME_W-1:0] sh_q, sh_d, frame_q, frame_d;
  logic [CFG_W-1:0]   cfgsh_q, cfgsh_d;
  logic [SPD_W-1:0]   spd_q;
  logic [CH_W-1:0]    ch_q;
  logic               commit;

  always_comb begin
    state_d    = state_q;
    fall_d     = fall_q;
    rise_d     = rise_q;
    sh_d       = sh_q;
    frame_d    = frame_q;
    cfgsh_d    = cfgsh_q;
    commit     = 1'b0;
    conv_start = 1'b0;
    unique case (state_q)
      ST_CONV: begin
        if (conv_done) begin
          frame_d = {2'b00, res_sign, res_data, {PAD_W{1'b0}}};
          state_d = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (!csn_s) begin
          state_d = ST_DOUT;
          sh_d    = frame_q;
          fall_d  = '0;
          rise_d  = '0;
        end
      end
      ST_DOUT: begin
        if (csn_rise) begin
          if (fall_q >= ABORT_L) begin
            state_d    = ST_CONV;
            conv_start = 1'b1;
            commit     = (fall_q >= COMMIT_L);
          end else begin
            state_d = ST_SLEEP;
          end
        end else begin
          if (sclk_fall) begin
            sh_d = {sh_q[FRAME_W-2:0], 1'b0};
            if (fall_q != FALL_MAX) fall_d = fall_q + 1'b1;
          end
          if (sclk_rise && (rise_q != RISE_MAX)) begin
            cfgsh_d = {cfgsh_q[CFG_W-2:0], sdi_s};
            rise_d  = rise_q + 1'b1;
          end
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CONV;
      fall_q  <= '0;
      rise_q  <= '0;
      sh_q    <= '0;
      frame_q <= '0;
      cfgsh_q <= '0;
      spd_q   <= SPD_RST;
      ch_q    <= CH_RST;
    end else begin
      state_q <= state_d;
      fall_q  <= fall_d;
      rise_q  <= rise_d;
      sh_q    <= sh_d;
      frame_q <= frame_d;
      cfgsh_q <= cfgsh_d;
      if (commit) begin
        spd_q <= cfgsh_q[CFG_W-1:CH_W];
        ch_q  <= cfgsh_q[CH_W-1:0];
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_DOUT: sdo = sh_q[FRAME_W-1];
      ST_CONV: sdo = 1'b1;
      default: sdo = 1'b0;
    endcase
  end

  assign sdo_oe    = !csn_s;
  assign busy      = (state_q != ST_SLEEP);
  assign cfg_speed = spd_q;
  assign cfg_chan  = ch_q;

  // R4
  ready_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOUT && fall_q == '0) |-> !sdo);

  // R4
  fall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q <= FALL_MAX);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({spd_q, ch_q}));

  // R7
  short_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOUT && csn_rise && fall_q < ABORT_L)
      |=> (state_q == ST_SLEEP && $stable(frame_q)));
endmodule

// File: rtl/cnv_serial_port.sv
module cnv_serial_port #(
  parameter int FRAME_W     = 32,
  parameter int DATA_W      = 24,
  parameter int SPD_W       = 5,
  parameter int CH_W        = 8,
  parameter int CONV_CYCLES = 4000,
  parameter int ABORT_MIN   = 5,
  parameter int COMMIT_MIN  = 14,
  parameter logic [SPD_W-1:0] SPD_RST = 1,
  parameter logic [CH_W-1:0]  CH_RST  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csn,
  input  logic              sdi,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_sign,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic [SPD_W-1:0]  cfg_speed,
  output logic [CH_W-1:0]   cfg_chan
);
  logic rst_m, rst_i;
  logic csn_s, sdi_s, csn_rise, sclk_rise, sclk_fall;
  logic conv_start, conv_run, conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_i <= rst_m;
    end
  end

  cnv_pin_sync u_sync (
    .clk(clk), .rst_n(rst_i), .sclk(sclk), .csn(csn), .sdi(sdi),
    .csn_s(csn_s), .sdi_s(sdi_s), .csn_rise(csn_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  cnv_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i), .start(conv_start),
    .running(conv_run), .done(conv_done)
  );

  cnv_frame_engine #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .SPD_W(SPD_W), .CH_W(CH_W),
    .ABORT_MIN(ABORT_MIN), .COMMIT_MIN(COMMIT_MIN),
    .SPD_RST(SPD_RST), .CH_RST(CH_RST)
  ) u_engine (
    .clk(clk), .rst_n(rst_i), .csn_s(csn_s), .sdi_s(sdi_s),
    .csn_rise(csn_rise), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .conv_done(conv_done), .res_data(res_data), .res_sign(res_sign),
    .conv_start(conv_start), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
    .cfg_speed(cfg_speed), .cfg_chan(cfg_chan)
  );

  // R9
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_i)
    conv_start |=> conv_run);

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_i)
    conv_done |-> busy);
endmodule

// File: tb/cnv_serial_port_bench.sv
module cnv_serial_port_bench;
  localparam int CONV = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, res_sign = 1'b0;
  logic [23:0] res_data = '0;
  logic sdo, sdo_oe, busy;
  logic [4:0] cfg_speed;
  logic [7:0] cfg_chan;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  cnv_serial_port #(.CONV_CYCLES(CONV)) u_cnv_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .res_data(res_data), .res_sign(res_sign), .sdo(sdo), .sdo_oe(sdo_oe),
    .busy(busy), .cfg_speed(cfg_speed), .cfg_chan(cfg_chan)
  );

  // vector: {sign, result, 13-bit configuration}
  localparam logic [37:0] VEC [4] = '{
    {1'b0, 24'h123456, 13'h0A5C},
    {1'b1, 24'hFFFFFF, 13'h1FFF},
    {1'b0, 24'h000001, 13'h0000},
    {1'b1, 24'hA5C3E1, 13'h1234}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    tick(4);
  endtask

  task automatic frame(input logic [12:0] cfg, input int nfall, output logic [31:0] rd);
    rd = '0;
    csn = 1'b0;
    tick(8);
    for (int k = 0; k < nfall; k++) begin
      sdi = (k < 13) ? cfg[12-k] : 1'b0;
      tick(4);
      rd[31-k] = sdo;
      sclk = 1'b1;
      tick(8);
      sclk = 1'b0;
      tick(8);
    end
    csn = 1'b1;
    tick(8);
  endtask

  function automatic logic [31:0] word(input logic s, input logic [23:0] d);
    return {2'b00, s, d, 5'b00000};
  endfunction

  logic [31:0] rd, exp_w;
  logic [12:0] last_cfg;

  initial begin
    res_sign = VEC[0][37];
    res_data = VEC[0][36:13];
    tick(5);
    rst_n = 1'b1;
    tick(6);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd1);
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    chk("R1 speed", 32'(cfg_speed), 32'd1);
    chk("R1 chan", 32'(cfg_chan), 32'd0);
    // R3 poll during conversion
    csn = 1'b0; tick(6);
    chk("R2 oe low cs", 32'(sdo_oe), 32'd1);
    chk("R3 poll busy", 32'(sdo), 32'd1);
    csn = 1'b1; tick(6);
    chk("R2 oe high cs", 32'(sdo_oe), 32'd0);

    for (int i = 0; i < 4; i++) begin
      res_sign = VEC[i][37];
      res_data = VEC[i][36:13];
      wait_idle();
      chk("R8 sleep busy", 32'(busy), 32'd0);
      frame(VEC[i][12:0], 32, rd);
      chk("R4 frame", rd, word(VEC[i][37], VEC[i][36:13]));
      chk("R8 conv busy", 32'(busy), 32'd1);
      chk("R5 speed", 32'(cfg_speed), 32'(VEC[i][12:8]));
      chk("R5 chan", 32'(cfg_chan), 32'(VEC[i][7:0]));
    end
    last_cfg = VEC[3][12:0];

    // R9 conversion length
    res_sign = 1'b0; res_data = 24'h3C3C3C;
    tick(CONV - 40);
    chk("R9 still busy", 32'(busy), 32'd1);
    tick(80);
    chk("R9 done", 32'(busy), 32'd0);

    // R7 short abort at 4 falling edges
    exp_w = word(1'b0, 24'h3C3C3C);
    frame(13'h0F0F, 4, rd);
    chk("R7 partial bits", {28'd0, rd[31:28]}, {28'd0, exp_w[31:28]});
    chk("R7 back to sleep", 32'(busy), 32'd0);
    chk("R7 cfg kept", 32'({cfg_speed, cfg_chan}), 32'(last_cfg));
    csn = 1'b0; tick(8);
    chk("R8 busy in readout", 32'(busy), 32'd1);
    chk("R4 ready before clocks", 32'(sdo), 32'd0);
    csn = 1'b1; tick(8);
    res_sign = 1'b1; res_data = 24'h00FF00;
    frame(13'h0ABC, 32, rd);
    chk("R7 word kept", rd, exp_w);
    last_cfg = 13'h0ABC;

    // R6 abort at exactly 5 falling edges
    wait_idle();
    frame(13'h1555, 5, rd);
    chk("R6 new conversion", 32'(busy), 32'd1);
    chk("R6 cfg kept", 32'({cfg_speed, cfg_chan}), 32'(last_cfg));
    csn = 1'b0; tick(6);
    chk("R6 poll", 32'(sdo), 32'd1);
    csn = 1'b1; tick(6);

    // R6 abort at 13 falling edges: no commit
    wait_idle();
    frame(13'h0777, 13, rd);
    chk("R6 13 edges cfg kept", 32'({cfg_speed, cfg_chan}), 32'(last_cfg));

    // R5 abort at 14 falling edges: commit
    wait_idle();
    frame(13'h0777, 14, rd);
    chk("R5 14 edges commit", 32'({cfg_speed, cfg_chan}), 32'(13'h0777));
    chk("R6 14 edges busy", 32'(busy), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule